// File: doc/BRIEF.md
# Clock-Controlled Dual-Register Keystream Generator

This block is a bit-serial keystream core built from two shift registers. A 128-stage linear register (the control register) advances once per iteration; a 89-stage register with a nonlinear feedback term (the data register) advances a variable number of times per iteration, and that count is read from two stages of the control register. A five-input Boolean selector, also fed from the control register, decides whether the data register's output bit is kept. Kept bits leave the block as keystream.

Software-free use is simple: present a 128-bit key and a 64-bit IV and pulse `start`. The core loads both registers, runs a fixed mixing phase of 200 iterations with `busy` high, and during that phase the selected bit is folded back into the top stage of both registers. Once `busy` drops, the core runs keystream iterations without end and pulses `ks_valid` for one cycle per kept bit. A new `start` after the mixing phase reloads and restarts; a `start` during the mixing phase has no effect.

Top module: `ccks_core`

## Requirements
- R1: While reset is low and after its release, `busy`, `ks_valid` and `ks_bit` are 0; with no `start`, they stay 0.
- R2: A `start` sampled while `busy` is 0 loads control stage i with `key[i]` (i = 0..127), data stage i with `iv[i]` (i = 0..63) and data stages 64..88 with 1; `busy` is 1 from the next cycle.
- R3: Both registers shift toward stage 0; the control register's new stage 127 is the XOR of its stages 0, 1, 6, 7, 8, 9, 11, 14, 15, 16, 17, 18, 23, 25, 29, 30, 35, 36, 39, 40, 43, 44, 47, 49, 50, 51, 52, 53, 55, 56, 57, 58, 60, 61, 65, 66, 67, 70, 71, 72, 73, 74, 77, 79, 80, 81, 82, 87, 90, 94, 96, 102, 103, 104, 105, 106, 108, 111, 115, 117, 119, 122, 123, 124, 125 and 126.
- R4: The data register's new stage 88 is the XOR of its stages 0, 1, 39, 42, 53, 55, 80, 83, further XORed with the AND of the inverses of its stages 1 to 88.
- R5: Each iteration takes c + 2 cycles: one cycle advancing the control register, then c cycles of one data step each, then one finishing cycle; c = 1 + A[0] + 2·A[64], read after the control advance, so c is 1 to 4.
- R6: The keep selector is g = x1 ⊕ x4 ⊕ x0x3 ⊕ x2x3 ⊕ x3x4 ⊕ x0x1x2 ⊕ x0x2x3 ⊕ x0x2x4 ⊕ x1x2x4 ⊕ x2x3x4 with x0..x4 = control stages 7, 37, 73, 91, 123, read after the control advance.
- R7: The mixing phase is 200 iterations; in its finishing cycle with g = 1, data stage 0 is XORed into control stage 127 and data stage 88. `busy` falls in the cycle after the finishing cycle of iteration 200, and `ks_valid` is 0 throughout the phase.
- R8: In keystream iterations with g = 1, `ks_valid` is 1 for exactly the cycle after the finishing cycle with `ks_bit` equal to data stage 0; otherwise `ks_valid` and `ks_bit` are 0. An all-zero key never yields a kept bit.
- R9: A `start` while `busy` is 1 is ignored: the running mixing phase and the keystream that follows are unchanged.
- R10: A `start` during keystream generation, at any point of an iteration, abandons that iteration, reloads key and IV and restarts the 200-iteration phase.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | Load key and IV and begin mixing |
| key | input | 128 | Key, bit i goes to control stage i |
| iv | input | 64 | IV, bit i goes to data stage i |
| busy | output | 1 | High during the 200-iteration mixing phase |
| ks_bit | output | 1 | Keystream bit, valid with ks_valid |
| ks_valid | output | 1 | One-cycle strobe per kept bit |

## Verification
Every iteration lasts c + 2 cycles, so the time of each result depends on the data: the bench's own model of the two registers computes c and g for every iteration and then waits exactly c + 2 falling edges before expecting the strobe. At each falling edge inside an iteration it compares `busy`, `ks_valid` and `ks_bit` with what the model predicts for that cycle, so a strobe one cycle early or late, or a `busy` that falls one iteration off, is reported. `busy` is expected high at the first falling edge after the start edge, and low from the falling edge after the 200th finishing cycle.

// File: rtl/ccks_pkg.sv
// Package: shared constants, state encodings and the keep selector
// for the clock-controlled dual-register keystream core.
// Assumes both registers shift toward stage 0 and feed the top stage.
package ccks_pkg;

    localparam int A_LEN  = 128;
    localparam int B_LEN  = 89;
    localparam int IV_LEN = 64;

    // Control register taps, bit k set when stage k enters the feedback.
    localparam logic [A_LEN-1:0] A_FB_MASK =
        128'h7CA8_97C1_4487_A7CE_37BE_9998_6287_CBC3;

    // Data register linear taps.
    localparam logic [B_LEN-1:0] B_FB_MASK =
        (B_LEN'(1) << 0)  | (B_LEN'(1) << 1)  | (B_LEN'(1) << 39) |
        (B_LEN'(1) << 42) | (B_LEN'(1) << 53) | (B_LEN'(1) << 55) |
        (B_LEN'(1) << 80) | (B_LEN'(1) << 83);

    // Selector input stages, x0 first.
    localparam int SEL_X0 = 7;
    localparam int SEL_X1 = 37;
    localparam int SEL_X2 = 73;
    localparam int SEL_X3 = 91;
    localparam int SEL_X4 = 123;

    typedef enum logic [1:0] {MODE_IDLE, MODE_INIT, MODE_GEN} mode_e;
    typedef enum logic [1:0] {PH_ADV, PH_STEP, PH_FIN} phase_e;

    // Keep selector over five control-register stages.
    function automatic logic keep_fn(input logic [4:0] x);
        return x[1] ^ x[4] ^ (x[0] & x[3]) ^ (x[2] & x[3]) ^ (x[3] & x[4])
             ^ (x[0] & x[1] & x[2]) ^ (x[0] & x[2] & x[3])
             ^ (x[0] & x[2] & x[4]) ^ (x[1] & x[2] & x[4])
             ^ (x[2] & x[3] & x[4]);
    endfunction

endpackage

// File: rtl/ccks_fsr.sv
// Feedback shift register toward stage 0 with parallel load, one shift
// per enabled cycle, and an XOR injection into the top stage.
// NL_TERM selects an extra feedback term: the AND of the inverses of
// stages 1..LEN-1. Priority: load, then shift, then inject.
module ccks_fsr #(
    parameter int                LEN     = 8,
    parameter logic [LEN-1:0]    FB_MASK = '1,
    parameter bit                NL_TERM = 1'b0
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           load,
    input  logic [LEN-1:0] load_val,
    input  logic           shift,
    input  logic           inj_en,
    input  logic           inj_bit,
    output logic [LEN-1:0] state
);

    logic lin_fb;
    logic nl_fb;

    assign lin_fb = ^(state & FB_MASK);

    generate
        if (NL_TERM) begin : g_nl
            assign nl_fb = &(~state[LEN-1:1]);
        end else begin : g_lin
            assign nl_fb = 1'b0;
        end
    endgenerate

    // Register update: load, shift or top-stage injection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= '0;
        end else if (load) begin
            state <= load_val;
        end else if (shift) begin
            state <= {lin_fb ^ nl_fb, state[LEN-1:1]};
        end else if (inj_en) begin
            state[LEN-1] <= state[LEN-1] ^ inj_bit;
        end
    end

endmodule

// File: rtl/ccks_sel.sv
// Step count and keep decision, both combinational on the control
// register. Count taps sit at stages k*CNT_STRIDE, k = 0..CNT_W-1,
// weighted 2^k; the count is that sum plus one.
// Assumes CNT_STRIDE*(CNT_W-1) < A_LEN.
module ccks_sel
    import ccks_pkg::*;
#(
    parameter int CNT_W      = 2,
    parameter int CNT_STRIDE = 64
) (
    input  logic [A_LEN-1:0] a_state,
    output logic [CNT_W:0]   c_val,
    output logic             keep
);

    logic [CNT_W-1:0] idx;

    generate
        for (genvar k = 0; k < CNT_W; k++) begin : g_tap
            assign idx[k] = a_state[k*CNT_STRIDE];
        end
    endgenerate

    assign c_val = {1'b0, idx} + 1'b1;
    assign keep  = keep_fn({a_state[SEL_X4], a_state[SEL_X3], a_state[SEL_X2],
                            a_state[SEL_X1], a_state[SEL_X0]});

endmodule

// File: rtl/ccks_ctrl.sv
// Iteration sequencer: advance control register, step the data register
// c times, finish. Counts INIT_ITERS mixing iterations, then keeps
// generating until a new start. Start is taken unless mixing is running.
module ccks_ctrl
    import ccks_pkg::*;
#(
    parameter int INIT_ITERS = 200,
    parameter int CNT_W      = 2
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           start,
    input  logic [CNT_W:0] c_val,
    output logic           load,
    output logic           a_shift,
    output logic           b_step,
    output logic           fin,
    output logic           in_init,
    output logic           in_gen,
    output logic [CNT_W:0] cnt
);

    localparam int ITER_W = $clog2(INIT_ITERS + 1);
    localparam logic [ITER_W-1:0] ITER_LAST = ITER_W'(INIT_ITERS - 1);

    mode_e             mode;
    phase_e            phase;
    logic [ITER_W-1:0] iter;
    logic [CNT_W:0]    cnt_nxt;
    logic              run;

    assign in_init = (mode == MODE_INIT);
    assign in_gen  = (mode == MODE_GEN);
    assign load    = start && !in_init;
    assign run     = (mode != MODE_IDLE) && !load;
    assign a_shift = run && (phase == PH_ADV);
    assign b_step  = run && (phase == PH_STEP);
    assign fin     = run && (phase == PH_FIN);
    assign cnt_nxt = cnt + 1'b1;

    // Mode, phase, step counter and mixing-iteration counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode  <= MODE_IDLE;
            phase <= PH_ADV;
            iter  <= '0;
            cnt   <= '0;
        end else if (load) begin
            mode  <= MODE_INIT;
            phase <= PH_ADV;
            iter  <= '0;
            cnt   <= '0;
        end else if (run) begin
            case (phase)
                PH_ADV: begin
                    phase <= PH_STEP;
                    cnt   <= '0;
                end
                PH_STEP: begin
                    cnt <= cnt_nxt;
                    if (cnt_nxt == c_val) begin
                        phase <= PH_FIN;
                    end
                end
                PH_FIN: begin
                    phase <= PH_ADV;
                    if (in_init) begin
                        iter <= iter + 1'b1;
                        if (iter == ITER_LAST) begin
                            mode <= MODE_GEN;
                        end
                    end
                end
                default: phase <= PH_ADV;
            endcase
        end
    end

endmodule

// File: rtl/ccks_core.sv
// Top of the clock-controlled dual-register keystream core. Wires the
// control register, data register, selector and sequencer, and registers
// the keystream strobe. Assumes key and iv are stable in the start cycle.
module ccks_core
    import ccks_pkg::*;
#(
    parameter int INIT_ITERS = 200,
    parameter int CNT_W      = 2,
    parameter int CNT_STRIDE = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [A_LEN-1:0]  key,
    input  logic [IV_LEN-1:0] iv,
    output logic              busy,
    output logic              ks_bit,
    output logic              ks_valid
);

    localparam int PAD_LEN = B_LEN - IV_LEN;

    logic [A_LEN-1:0] a_state;
    logic [B_LEN-1:0] b_state;
    logic [B_LEN-1:0] b_seed;
    logic [CNT_W:0]   c_w;
    logic [CNT_W:0]   cnt_w;
    logic             keep_w;
    logic             load_w;
    logic             a_shift_w;
    logic             b_step_w;
    logic             fin_w;
    logic             in_init_w;
    logic             in_gen_w;
    logic             inj_w;
    logic             emit_w;

    assign b_seed = {{PAD_LEN{1'b1}}, iv};
    assign inj_w  = fin_w && in_init_w && keep_w;
    assign emit_w = fin_w && in_gen_w && keep_w;
    assign busy   = in_init_w;

    ccks_fsr #(.LEN(A_LEN), .FB_MASK(A_FB_MASK), .NL_TERM(1'b0)) u_areg (
        .clk(clk), .rst_n(rst_n), .load(load_w), .load_val(key),
        .shift(a_shift_w), .inj_en(inj_w), .inj_bit(b_state[0]),
        .state(a_state)
    );

    ccks_fsr #(.LEN(B_LEN), .FB_MASK(B_FB_MASK), .NL_TERM(1'b1)) u_breg (
        .clk(clk), .rst_n(rst_n), .load(load_w), .load_val(b_seed),
        .shift(b_step_w), .inj_en(inj_w), .inj_bit(b_state[0]),
        .state(b_state)
    );

    ccks_sel #(.CNT_W(CNT_W), .CNT_STRIDE(CNT_STRIDE)) u_sel (
        .a_state(a_state), .c_val(c_w), .keep(keep_w)
    );

    ccks_ctrl #(.INIT_ITERS(INIT_ITERS), .CNT_W(CNT_W)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .start(start), .c_val(c_w),
        .load(load_w), .a_shift(a_shift_w), .b_step(b_step_w), .fin(fin_w),
        .in_init(in_init_w), .in_gen(in_gen_w), .cnt(cnt_w)
    );

    // Keystream output register: one-cycle strobe per kept bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ks_valid <= 1'b0;
            ks_bit   <= 1'b0;
        end else begin
            ks_valid <= emit_w;
            ks_bit   <= emit_w & b_state[0];
        end
    end

endmodule

// File: rtl/ccks_core_chk.sv
// Checker for ccks_core: strobe shape, quiet mixing phase, start-only
// entry into mixing and per-iteration step count. Bound to every
// ccks_core instance below.
module ccks_core_chk #(
    parameter int CNT_W = 2
) (
    input logic           clk,
    input logic           rst_n,
    input logic           start,
    input logic           busy,
    input logic           ks_valid,
    input logic           fin,
    input logic [CNT_W:0] cnt,
    input logic [CNT_W:0] c_val
);

    localparam logic [CNT_W:0] C_MAX = (CNT_W+1)'(1) << CNT_W;

    // R8: the strobe never lasts two cycles.
    a_r8_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        ks_valid |=> !ks_valid);

    // R7: no kept bit leaves while mixing.
    a_r7_quiet_mixing: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !ks_valid);

    // R2: mixing is only ever entered by a start.
    a_r2_busy_from_start: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(start));

    // R5: the finishing cycle comes after exactly c data steps.
    a_r5_step_count: assert property (@(posedge clk) disable iff (!rst_n)
        fin |-> (cnt == c_val));

    // R5: the step counter never passes the largest count.
    a_r5_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= C_MAX);

endmodule

bind ccks_core ccks_core_chk #(.CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .start(start), .busy(busy),
    .ks_valid(ks_valid), .fin(fin_w), .cnt(cnt_w), .c_val(c_w)
);

// File: tb/sim_ccks_core.sv
// Directed bench for ccks_core with a bit-level model of both registers.
module sim_ccks_core;

    localparam int CLK_PERIOD = 10;
    localparam int N_INIT     = 200;
    localparam logic [127:0] M_AMASK =
        128'h7CA8_97C1_4487_A7CE_37BE_9998_6287_CBC3;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start = 1'b0;
    logic [127:0] key = '0;
    logic [63:0]  iv = '0;
    logic         busy;
    logic         ks_bit;
    logic         ks_valid;

    int n_chk = 0;
    int n_fail = 0;

    logic [127:0] ma;
    logic [88:0]  mb;

    ccks_core u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .key(key), .iv(iv),
        .busy(busy), .ks_bit(ks_bit), .ks_valid(ks_valid)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [2:0] act, input logic [2:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
        end
    endtask

    function automatic logic m_keep(input logic [127:0] a);
        logic x0, x1, x2, x3, x4;
        x0 = a[7]; x1 = a[37]; x2 = a[73]; x3 = a[91]; x4 = a[123];
        return x1 ^ x4 ^ (x0 & x3) ^ (x2 & x3) ^ (x3 & x4) ^ (x0 & x1 & x2)
             ^ (x0 & x2 & x3) ^ (x0 & x2 & x4) ^ (x1 & x2 & x4) ^ (x2 & x3 & x4);
    endfunction

    // Model of one iteration (R3, R4, R5, R6, R7).
    task automatic m_iter(input bit mixing, output int c, output bit g, output bit o);
        logic fa, fb;
        fa = ^(ma & M_AMASK);
        ma = {fa, ma[127:1]};
        c = 1 + int'(ma[0]) + 2 * int'(ma[64]);
        g = m_keep(ma);
        for (int s = 0; s < c; s++) begin
            fb = mb[0] ^ mb[1] ^ mb[39] ^ mb[42] ^ mb[53] ^ mb[55] ^ mb[80]
               ^ mb[83] ^ (&(~mb[88:1]));
            mb = {fb, mb[88:1]};
        end
        o = mb[0];
        if (mixing && g) begin
            ma[127] = ma[127] ^ o;
            mb[88]  = mb[88] ^ o;
        end
    endtask

    // Pulse start at the current falling edge; model loads (R2).
    task automatic pulse_start(input logic [127:0] k, input logic [63:0] v);
        key = k; iv = v; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        ma = k;
        mb = {{25{1'b1}}, v};
        chk(busy === 1'b1, "R2", "busy after start", {busy, 2'b00}, 3'b100);
    endtask

    // One iteration checked at every falling edge; poke drives a start mid-way.
    task automatic iter_once(input bit mixing, input bit last, input bit poke,
                             input string req, output bit kept);
        int c; bit g, o;
        bit ok;
        logic [2:0] act, exp, a1, e1;
        m_iter(mixing, c, g, o);
        ok = 1'b1; a1 = '0; e1 = '0;
        for (int k = 0; k < c + 2; k++) begin
            @(negedge clk);
            exp[1] = (k == c + 1) && !mixing && g;
            exp[0] = exp[1] & o;
            exp[2] = mixing && !(last && k == c + 1);
            act = {busy, ks_valid, ks_bit};
            if (act !== exp && ok) begin
                ok = 1'b0; a1 = act; e1 = exp;
            end
            if (poke && k == 0) begin
                key = ~key; iv = ~iv; start = 1'b1;
            end
            if (poke && k == 1) start = 1'b0;
        end
        kept = !mixing && g;
        chk(ok, req, "iteration {busy,valid,bit}", a1, e1);
    endtask

    // Full mixing phase then ngen keystream iterations.
    task automatic run_pair(input logic [127:0] k, input logic [63:0] v,
                            input int ngen, input bit poke, output int nkept);
        bit kept;
        pulse_start(k, v);
        for (int i = 0; i < N_INIT; i++)
            iter_once(1'b1, i == N_INIT - 1, poke && i == 50,
                      poke ? "R9" : "R7", kept);
        nkept = 0;
        for (int i = 0; i < ngen; i++) begin
            iter_once(1'b0, 1'b0, 1'b0, "R8 R3 R4 R5 R6", kept);
            if (kept) nkept++;
        end
    endtask

    task automatic t_reset;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk({busy, ks_valid, ks_bit} === 3'b000, "R1", "in reset",
            {busy, ks_valid, ks_bit}, 3'b000);
        rst_n = 1'b1;
        repeat (6) @(negedge clk);
        chk({busy, ks_valid, ks_bit} === 3'b000, "R1", "idle without start",
            {busy, ks_valid, ks_bit}, 3'b000);
    endtask

    task automatic t_pattern;
        int nk;
        run_pair({32'h0123_4567, 32'h89AB_CDEF, 32'hFEDC_BA98, 32'h7654_3210},
                 64'hDEAD_BEEF_0BAD_F00D, 120, 1'b0, nk);
        chk(nk > 0, "R8", "kept bits seen", 3'(nk > 0), 3'b001);
    endtask

    task automatic t_all_ones;
        int nk;
        run_pair('1, '1, 80, 1'b0, nk);
        chk(nk > 0, "R8", "kept bits seen, ones", 3'(nk > 0), 3'b001);
    endtask

    task automatic t_zero_key;
        int nk;
        run_pair('0, 64'h5555_AAAA_5555_AAAA, 60, 1'b0, nk);
        chk(nk == 0, "R8", "zero key keeps nothing", 3'(nk), 3'b000);
        chk(ks_valid === 1'b0, "R8", "zero key strobe", {2'b00, ks_valid}, 3'b000);
    endtask

    task automatic t_ignore_start;
        int nk;
        run_pair({4{32'hC3A5_1E96}}, 64'h0F0F_1234_8765_F0F0, 100, 1'b1, nk);
        chk(nk > 0, "R9", "keystream after ignored start", 3'(nk > 0), 3'b001);
    endtask

    task automatic t_restart;
        int nk;
        run_pair({4{32'h1357_9BDF}}, 64'h2468_ACE0_1357_9BDF, 30, 1'b0, nk);
        repeat (2) @(negedge clk);
        run_pair({4{32'hA0B1_C2D3}}, 64'hFFFF_0000_1234_5678, 80, 1'b0, nk);
        chk(nk > 0, "R10", "keystream after reload", 3'(nk > 0), 3'b001);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual hung expected done");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        @(negedge clk);
        t_reset();
        t_pattern();
        t_all_ones();
        t_zero_key();
        t_ignore_start();
        t_restart();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule